// File: doc/BRIEF.md
# Codec Register Write Sequencer

This block sits between a register-programming agent and a serial control-bus write master that talks to an audio codec. The codec offers fourteen byte-wide registers and none of them can be read back, so the block holds a shadow copy of every register. It serves reads from that copy through a combinational port and turns each accepted write into one or two bus transactions. Each transaction is an address byte plus a data byte.

Registers 8 and 9 are status registers and are written at bus address type 2. Registers 10, 11 and 12 form the primary bank and use type 0. Register 13 is the secondary register and uses type 1. All bus addresses carry the device number 5 in bits 7:2 and the type in bits 1:0, so the only bus addresses used are 0x14, 0x15 and 0x16. Registers 0 to 7 are indirect registers and need two transactions, both sent to 0x14: first a selector byte, then a value byte.

A replay command rewrites every shadow entry onto the bus in index order. It is used to bring a codec back in step with the shadow after its supply has been cycled. Only one operation is in flight at a time. Each operation ends with a one-cycle response that says ok or error.

Top module: `codec_regwr_seq`

## Requirements
- R1: After reset the shadow holds, for indices 0 to 13: 0x04, 0x04, 0x04, 0x00, 0x00, 0x00, 0x00, 0x00, 0x00, 0x83, 0x00, 0x40, 0x80, 0x00.
- R2: A read of any index from 14 to 15 returns 0xFF.
- R3: An accepted in-range write (`req_replay` = 0) stores its value in the shadow at the acceptance edge. The new value is readable in the next cycle, before any bus transaction completes, and it stays stored even if the bus transfer later fails.
- R4: A write to index 8 or 9 issues one transaction with address 0x16. A write to index 10, 11 or 12 issues one transaction with address 0x14. A write to index 13 issues one transaction with address 0x15. In each case the data byte is the value.
- R5: A write to index 0 to 7 issues two transactions, both at address 0x14. The first carries data (0xC0 OR index). The second carries data (0xE0 OR value) and starts in the cycle right after the first completes.
- R6: A write to index 14 or 15 makes no bus transaction and leaves the shadow unchanged. In the cycle after acceptance it gives a response with `rsp_err` = 1.
- R7: `cbus_valid`, `cbus_addr` and `cbus_data` stay constant from the start of a transaction until the cycle in which `cbus_done` is sampled high.
- R8: When `cbus_done` and `cbus_fail` are both high, the operation ends. The next cycle carries a response with `rsp_err` = 1, and no further transaction of that operation is issued.
- R9: `req_ready` is high only when no operation is in flight. A request is accepted when `req_valid` and `req_ready` are both high, and `cbus_valid` is never high while `req_ready` is high.
- R10: A replay (`req_replay` = 1, index and value ignored) issues the transactions of indices 0 through 13 in that order, each using its R4/R5 mapping with the current shadow value. That is 22 transactions, and the replay ends with `rsp_err` = 0.
- R11: Every operation ends with `rsp_valid` high for exactly one cycle, in the cycle after its last transaction completes. `req_ready` returns high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_replay | input | 1 | 1 = replay all shadow entries, 0 = single write |
| req_idx | input | 4 | Register index for a write |
| req_wdata | input | 8 | Register value for a write |
| rd_idx | input | 4 | Shadow read index |
| rd_data | output | 8 | Shadow read value, combinational |
| cbus_valid | output | 1 | Transaction request to the bus write master |
| cbus_addr | output | 8 | Transaction address byte |
| cbus_data | output | 8 | Transaction data byte |
| cbus_done | input | 1 | Master finished the current transaction |
| cbus_fail | input | 1 | Qualifies `cbus_done`: the transaction failed |
| rsp_valid | output | 1 | Operation response, one cycle |
| rsp_err | output | 1 | Response carries an error |

## Verification
The assertions assume that the bus master raises `cbus_done` only while `cbus_valid` is high, and that `cbus_fail` only has meaning together with `cbus_done`. The bench's bus model keeps to this by pulsing completion only after it has seen a pending request, and it holds completion for exactly one cycle. The assertions also assume that requests are presented only through the ready handshake. The stimulus raises `req_valid` only when it expects the block to be idle and drops it right after the acceptance edge. Random writes over all sixteen index codes, with injected failures at random transaction positions, are mixed with directed replays and boundary indices.

// File: rtl/codec_seq_pkg.sv
package codec_seq_pkg;

    localparam int unsigned REG_COUNT     = 14;
    localparam int unsigned BYTE_W        = 8;
    localparam int unsigned IND_LAST      = 7;
    localparam int unsigned STATUS_FIRST  = 8;
    localparam int unsigned STATUS_LAST   = 9;
    localparam int unsigned SECONDARY_IDX = 13;

    localparam logic [5:0] DEVICE_NUM     = 6'd5;
    localparam logic [1:0] TYPE_PRIMARY   = 2'd0;
    localparam logic [1:0] TYPE_SECONDARY = 2'd1;
    localparam logic [1:0] TYPE_STATUS    = 2'd2;

    localparam logic [BYTE_W-1:0] SELECT_TAG = 8'hC0;
    localparam logic [BYTE_W-1:0] VALUE_TAG  = 8'hE0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_RESP = 2'd2
    } seq_state_e;

    typedef enum logic {
        PH_SELECT = 1'b0,
        PH_VALUE  = 1'b1
    } seq_phase_e;

    typedef struct packed {
        logic [BYTE_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } bus_xact_t;

    function automatic logic [BYTE_W-1:0] reset_value(int unsigned i);
        case (i)
            0, 1, 2: return 8'h04;
            9:       return 8'h83;
            11:      return 8'h40;
            12:      return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic is_indirect(int unsigned i);
        return i <= IND_LAST;
    endfunction

    function automatic logic [1:0] addr_type(int unsigned i);
        if (i >= STATUS_FIRST && i <= STATUS_LAST) return TYPE_STATUS;
        if (i == SECONDARY_IDX)                    return TYPE_SECONDARY;
        return TYPE_PRIMARY;
    endfunction

    function automatic logic [BYTE_W-1:0] bus_addr(logic [1:0] t);
        return {DEVICE_NUM, t};
    endfunction

    function automatic seq_phase_e first_phase(int unsigned i);
        return is_indirect(i) ? PH_SELECT : PH_VALUE;
    endfunction

endpackage

// File: rtl/codec_shadow_regs.sv
module codec_shadow_regs
    import codec_seq_pkg::*;
#(
    parameter int unsigned COUNT  = REG_COUNT,
    parameter int unsigned DATA_W = BYTE_W,
    localparam int unsigned IDX_W = $clog2(COUNT),
    localparam int unsigned SLOTS = 2 ** IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data
);

    logic [DATA_W-1:0] mem_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < COUNT) begin : g_live
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem_q[g] <= DATA_W'(reset_value(g));
                end else if (wr_en && (32'(wr_idx) == g)) begin
                    mem_q[g] <= wr_data;
                end
            end
        end else begin : g_void
            // Unmapped index codes read as all ones.
            assign mem_q[g] = '1;
        end
    end

    assign rd_a_data = mem_q[rd_a_idx];
    assign rd_b_data = mem_q[rd_b_idx];

endmodule

// File: rtl/codec_bus_map.sv
module codec_bus_map
    import codec_seq_pkg::*;
#(
    parameter int unsigned IDX_W = 4
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] value,
    input  seq_phase_e        phase,
    output bus_xact_t         xact
);

    always_comb begin
        if (is_indirect(32'(idx))) begin
            xact.addr = bus_addr(TYPE_PRIMARY);
            if (phase == PH_SELECT) begin
                xact.data = BYTE_W'(idx) | SELECT_TAG;
            end else begin
                xact.data = value | VALUE_TAG;
            end
        end else begin
            xact.addr = bus_addr(addr_type(32'(idx)));
            xact.data = value;
        end
    end

endmodule

// File: rtl/codec_seq_ctrl.sv
module codec_seq_ctrl
    import codec_seq_pkg::*;
#(
    parameter int unsigned COUNT = REG_COUNT,
    localparam int unsigned IDX_W = $clog2(COUNT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_replay,
    input  logic [IDX_W-1:0] req_idx,
    output logic             req_ready,
    output logic             shadow_we,
    output logic [IDX_W-1:0] cur_idx,
    output seq_phase_e       cur_phase,
    output logic             bus_valid,
    input  logic             bus_done,
    input  logic             bus_fail,
    output logic             rsp_valid,
    output logic             rsp_err
);

    seq_state_e       state_q;
    seq_phase_e       phase_q;
    logic [IDX_W-1:0] idx_q;
    logic             replay_q;
    logic             err_q;

    logic accept;
    logic in_range;
    logic last_idx;

    assign accept   = req_valid && (state_q == ST_IDLE);
    assign in_range = 32'(req_idx) < COUNT;
    assign last_idx = 32'(idx_q) == COUNT - 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            phase_q  <= PH_VALUE;
            idx_q    <= '0;
            replay_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        replay_q <= req_replay;
                        err_q    <= 1'b0;
                        if (req_replay) begin
                            idx_q   <= '0;
                            phase_q <= first_phase(0);
                            state_q <= ST_XFER;
                        end else if (in_range) begin
                            idx_q   <= req_idx;
                            phase_q <= first_phase(32'(req_idx));
                            state_q <= ST_XFER;
                        end else begin
                            err_q   <= 1'b1;
                            state_q <= ST_RESP;
                        end
                    end
                end
                ST_XFER: begin
                    if (bus_done) begin
                        if (bus_fail) begin
                            err_q   <= 1'b1;
                            state_q <= ST_RESP;
                        end else if (phase_q == PH_SELECT) begin
                            phase_q <= PH_VALUE;
                        end else if (replay_q && !last_idx) begin
                            idx_q   <= idx_q + IDX_W'(1);
                            phase_q <= first_phase(32'(idx_q) + 1);
                        end else begin
                            state_q <= ST_RESP;
                        end
                    end
                end
                ST_RESP: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign shadow_we = accept && !req_replay && in_range;
    assign cur_idx   = idx_q;
    assign cur_phase = phase_q;
    assign bus_valid = (state_q == ST_XFER);
    assign rsp_valid = (state_q == ST_RESP);
    assign rsp_err   = (state_q == ST_RESP) && err_q;

endmodule

// File: rtl/codec_regwr_seq.sv
module codec_regwr_seq
    import codec_seq_pkg::*;
#(
    parameter int unsigned COUNT = REG_COUNT,
    localparam int unsigned IDX_W = $clog2(COUNT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_replay,
    input  logic [IDX_W-1:0]  req_idx,
    input  logic [BYTE_W-1:0] req_wdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BYTE_W-1:0] rd_data,
    output logic              cbus_valid,
    output logic [BYTE_W-1:0] cbus_addr,
    output logic [BYTE_W-1:0] cbus_data,
    input  logic              cbus_done,
    input  logic              cbus_fail,
    output logic              rsp_valid,
    output logic              rsp_err
);

    logic              shadow_we;
    logic [IDX_W-1:0]  cur_idx;
    seq_phase_e        cur_phase;
    logic [BYTE_W-1:0] cur_value;
    bus_xact_t         xact;

    codec_seq_ctrl #(
        .COUNT (COUNT)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_replay (req_replay),
        .req_idx    (req_idx),
        .req_ready  (req_ready),
        .shadow_we  (shadow_we),
        .cur_idx    (cur_idx),
        .cur_phase  (cur_phase),
        .bus_valid  (cbus_valid),
        .bus_done   (cbus_done),
        .bus_fail   (cbus_fail),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err)
    );

    codec_shadow_regs #(
        .COUNT  (COUNT),
        .DATA_W (BYTE_W)
    ) u_shadow (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (shadow_we),
        .wr_idx    (req_idx),
        .wr_data   (req_wdata),
        .rd_a_idx  (rd_idx),
        .rd_a_data (rd_data),
        .rd_b_idx  (cur_idx),
        .rd_b_data (cur_value)
    );

    codec_bus_map #(
        .IDX_W (IDX_W)
    ) u_map (
        .idx   (cur_idx),
        .value (cur_value),
        .phase (cur_phase),
        .xact  (xact)
    );

    assign cbus_addr = xact.addr;
    assign cbus_data = xact.data;

endmodule

// File: rtl/codec_regwr_seq_chk.sv
module codec_regwr_seq_chk
    import codec_seq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_replay,
    input logic [3:0]        req_idx,
    input logic [3:0]        rd_idx,
    input logic [BYTE_W-1:0] rd_data,
    input logic              cbus_valid,
    input logic [BYTE_W-1:0] cbus_addr,
    input logic [BYTE_W-1:0] cbus_data,
    input logic              cbus_done,
    input logic              cbus_fail,
    input logic              rsp_valid,
    input logic              rsp_err
);

    // R9
    single_flight_chk: assert property (@(posedge clk) disable iff (rst)
        cbus_valid |-> !req_ready);

    // R7
    bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cbus_valid && !cbus_done) |=>
            (cbus_valid && $stable(cbus_addr) && $stable(cbus_data)));

    // R4
    bus_addr_legal_chk: assert property (@(posedge clk) disable iff (rst)
        cbus_valid |-> (cbus_addr == bus_addr(TYPE_PRIMARY) ||
                        cbus_addr == bus_addr(TYPE_SECONDARY) ||
                        cbus_addr == bus_addr(TYPE_STATUS)));

    // R6
    bad_index_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_replay && (32'(req_idx) >= REG_COUNT)) |=>
            (rsp_valid && rsp_err && !cbus_valid));

    // R8
    fail_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (cbus_valid && cbus_done && cbus_fail) |=>
            (rsp_valid && rsp_err && !cbus_valid));

    // R11
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R2
    oob_read_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(rd_idx) >= REG_COUNT) |-> (rd_data == 8'hFF));

endmodule

bind codec_regwr_seq codec_regwr_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_replay (req_replay),
    .req_idx    (req_idx),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .cbus_valid (cbus_valid),
    .cbus_addr  (cbus_addr),
    .cbus_data  (cbus_data),
    .cbus_done  (cbus_done),
    .cbus_fail  (cbus_fail),
    .rsp_valid  (rsp_valid),
    .rsp_err    (rsp_err)
);

// File: tb/codec_regwr_seq_bench.sv
module codec_regwr_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NREG       = 14;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_replay = 1'b0;
    logic [3:0] req_idx = '0;
    logic [7:0] req_wdata = '0;
    logic [3:0] rd_idx = '0;
    logic [7:0] rd_data;
    logic       cbus_valid;
    logic [7:0] cbus_addr;
    logic [7:0] cbus_data;
    logic       cbus_done = 1'b0;
    logic       cbus_fail = 1'b0;
    logic       rsp_valid;
    logic       rsp_err;

    int vectors = 0;
    int miscompares = 0;
    logic [7:0] model [NREG];
    logic [7:0] exp_a [32];
    logic [7:0] exp_d [32];
    int         exp_n;

    always #(CLK_PERIOD / 2) clk = ~clk;

    codec_regwr_seq u_codec_regwr_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_replay (req_replay),
        .req_idx    (req_idx),
        .req_wdata  (req_wdata),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data),
        .cbus_valid (cbus_valid),
        .cbus_addr  (cbus_addr),
        .cbus_data  (cbus_data),
        .cbus_done  (cbus_done),
        .cbus_fail  (cbus_fail),
        .rsp_valid  (rsp_valid),
        .rsp_err    (rsp_err)
    );

    function automatic logic [7:0] power_on(int i);
        case (i)
            0, 1, 2: return 8'h04;
            9:       return 8'h83;
            11:      return 8'h40;
            12:      return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string map_tag(int i);
        return (i <= 7) ? "R5" : "R4";
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic push(int i, logic [7:0] v);
        if (i <= 7) begin
            exp_a[exp_n] = 8'h14; exp_d[exp_n] = 8'hC0 | 8'(i); exp_n++;
            exp_a[exp_n] = 8'h14; exp_d[exp_n] = 8'hE0 | v;     exp_n++;
        end else begin
            exp_a[exp_n] = (i <= 9) ? 8'h16 : ((i == 13) ? 8'h15 : 8'h14);
            exp_d[exp_n] = v;
            exp_n++;
        end
    endtask

    task automatic check_reads(string in_tag);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            rd_idx = 4'(i);
            #1;
            if (i < NREG) check(in_tag, rd_data, model[i]);
            else          check("R2", rd_data, 8'hFF);
        end
    endtask

    // One operation; fail_at selects which transaction the bus model fails (-1 none).
    task automatic run_op(bit replay, int idx, logic [7:0] val, int fail_at);
        bit    stop;
        bit    err_exp;
        string tag;
        exp_n = 0;
        if (replay) begin
            for (int i = 0; i < NREG; i++) push(i, model[i]);
            tag = "R10";
        end else if (idx < NREG) begin
            model[idx] = val;
            push(idx, val);
            tag = map_tag(idx);
        end else begin
            tag = "R6";
        end
        @(negedge clk);
        check("R9", req_ready, 1'b1);
        req_valid  = 1'b1;
        req_replay = replay;
        req_idx    = 4'(idx);
        req_wdata  = val;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9", req_ready, 1'b0);
        if (!replay && idx < NREG) begin
            rd_idx = 4'(idx);
            #1;
            check("R3", rd_data, val);
        end
        err_exp = 1'b0;
        stop    = 1'b0;
        if (!replay && idx >= NREG) begin
            check("R6", cbus_valid, 1'b0);
            err_exp = 1'b1;
        end else begin
            for (int k = 0; k < exp_n && !stop; k++) begin
                check(tag, cbus_valid, 1'b1);
                check(tag, cbus_addr, exp_a[k]);
                check(tag, cbus_data, exp_d[k]);
                repeat ($urandom % 3) begin
                    @(negedge clk);
                    check("R7", {cbus_valid, cbus_addr, cbus_data}, {1'b1, exp_a[k], exp_d[k]});
                end
                cbus_done = 1'b1;
                cbus_fail = (k == fail_at);
                @(negedge clk);
                cbus_done = 1'b0;
                cbus_fail = 1'b0;
                if (k == fail_at) begin
                    stop    = 1'b1;
                    err_exp = 1'b1;
                    check("R8", cbus_valid, 1'b0);
                end
            end
        end
        check("R11", rsp_valid, 1'b1);
        check(err_exp ? "R8" : "R11", rsp_err, err_exp);
        @(negedge clk);
        check("R11", {rsp_valid, req_ready}, 2'b01);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        vectors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < NREG; i++) model[i] = power_on(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9", req_ready, 1'b1);
        check("R11", rsp_valid, 1'b0);
        check("R9", cbus_valid, 1'b0);
        check_reads("R1");

        run_op(1'b1, 0, 8'h00, -1);     // R10 replay of reset contents
        run_op(1'b0, 9, 8'h5A, -1);     // R4 status
        run_op(1'b0, 8, 8'hC3, -1);     // R4 status
        run_op(1'b0, 13, 8'hA7, -1);    // R4 secondary
        run_op(1'b0, 11, 8'h3C, -1);    // R4 primary
        run_op(1'b0, 3, 8'h1F, -1);     // R5 indirect
        run_op(1'b0, 7, 8'hFF, -1);     // R5 indirect, top index
        run_op(1'b0, 0, 8'h00, -1);     // R5 indirect, index 0
        run_op(1'b0, 14, 8'h99, -1);    // R6
        run_op(1'b0, 15, 8'h11, -1);    // R6
        check_reads("R6");
        run_op(1'b0, 2, 8'h15, 0);      // R8 fail on selector phase
        run_op(1'b0, 5, 8'h0A, 1);      // R8 fail on value phase
        run_op(1'b0, 10, 8'h66, 0);     // R8 single-phase fail
        run_op(1'b1, 0, 8'h00, 9);      // R8 fail mid-replay
        check_reads("R3");
        run_op(1'b1, 0, 8'h00, -1);     // R10 replay after edits

        for (int n = 0; n < 60; n++) begin
            bit   rp;
            int   fa;
            rp = ($urandom % 10) == 0;
            fa = (($urandom % 6) == 0) ? int'($urandom % (rp ? 22 : 2)) : -1;
            run_op(rp, int'($urandom % 16), 8'($urandom), fa);
        end
        check_reads("R3");
        run_op(1'b1, 0, 8'h00, -1);     // R10

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule